// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, cycle by cycle, whether an in-order five-stage integer pipeline (fetch, decode, execute, memory, write-back) may advance. The front end presents the instruction now in decode: its source and destination register numbers and flags for register write, load, data-memory access and control transfer. From this the unit keeps its own copy of the control fields of the instructions further down the pipe, one per stage, and moves them along using its own stall and bubble decisions. A synchronous reset clears every copy, so the pipe starts out empty.

The unit has three kinds of outputs. The first holds the program counter or the decode register. The second discards the instruction just fetched or puts a bubble into execute. The third is a pair of operand-forward selects for execute. A redirect output tells the fetch logic to load the target of a jump or branch that has been resolved in decode. A parameter selects whether instruction and data memory are one shared memory or two separate memories. With a shared memory, a data access in the memory stage blocks that cycle's fetch.

All outputs are combinational from the decode inputs and the stage copies. This lets the datapath act on them in the same cycle.

Top module: `hz_ctrl_unit`

## Requirements
- R1: After synchronous reset (rst high) every tracked stage is empty. With no valid decode instruction, every hold, flush, bubble and redirect output is 0 and both forward selects are 0, whatever was in flight before reset.
- R2: With UNIFIED_MEM=1, a valid data-memory access in the memory stage raises pc_hold, ifid_hold and idex_bubble in that cycle. With UNIFIED_MEM=0 the same access raises none of them.
- R3: A valid control transfer in decode, with no stall pending, raises redirect and ifid_flush in that cycle with pc_hold at 0. This costs exactly one bubble, and in the following cycle redirect returns to 0.
- R4: When a structural stall and a control transfer in decode coincide, the stall wins: redirect and ifid_flush stay 0 and decode is held. redirect is raised in the first cycle in which fetch is free again.
- R5: A load in execute whose nonzero destination equals rs1 or rs2 of the valid decode instruction raises pc_hold, ifid_hold and idex_bubble for exactly one cycle. When the dependent instruction reaches execute, its operand is forwarded from the write-back stage (select 1).
- R6: Forward select encoding is 0 = register file, 1 = write-back stage result, 2 = memory stage result. A source of the execute instruction that matches the nonzero destination of a writing instruction in the memory stage gets select 2.
- R7: A source that matches only a writing instruction in the write-back stage gets select 1.
- R8: When both the memory-stage and the write-back-stage instructions write the same register that a source reads, the select is 2, because the memory-stage result is newer.
- R9: Register 0 is never a dependency: it produces neither a forward nor a load-use stall.
- R10: Write-after-read and write-after-write pairs never raise pc_hold or idex_bubble.
- R11: An older instruction whose register-write flag is 0 never produces a forward, even when its destination field matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, empties all tracked stages |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | AW | First source register of decode instruction |
| id_rs2 | input | AW | Second source register of decode instruction |
| id_rd | input | AW | Destination register of decode instruction |
| id_wr | input | 1 | Decode instruction writes its destination |
| id_load | input | 1 | Decode instruction is a load |
| id_mem | input | 1 | Decode instruction accesses data memory |
| id_ctrl | input | 1 | Decode instruction is a jump, call or branch |
| pc_hold | output | 1 | Keep the program counter, retry the fetch |
| ifid_hold | output | 1 | Keep the decode register contents |
| ifid_flush | output | 1 | Replace the just-fetched instruction with a bubble |
| idex_bubble | output | 1 | Send a bubble into execute instead of the decode instruction |
| redirect | output | 1 | Load the resolved transfer target into the program counter |
| fwd_a | output | 2 | Forward select for execute operand 1 |
| fwd_b | output | 2 | Forward select for execute operand 2 |

## Verification
The bench targets the cases where a wrong priority still looks plausible. One is a transfer meeting a shared-memory data access: a unit that redirects anyway would lose the transfer or fetch twice. Another is a load-use stall: one that never clears would hang the pipe, and one that skips the bubble would feed execute a stale value. Forward priority with both stages matching is checked, because the wrong choice returns the older result. Register 0 and non-writing instructions are checked, because a careless match forwards garbage. WAR and WAW pairs and a reset mid-flight are also covered, since those pairs would cost needless stalls and the reset would leave phantom dependencies behind.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_WB  = 2'd1,
    FWD_MEM = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_track.sv
module hz_track #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idex_bubble,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] id_rd,
  input  logic          id_wr,
  input  logic          id_load,
  input  logic          id_mem,
  output logic          ex_valid,
  output logic [AW-1:0] ex_rs1,
  output logic [AW-1:0] ex_rs2,
  output logic [AW-1:0] ex_rd,
  output logic          ex_wr,
  output logic          ex_load,
  output logic          mem_valid,
  output logic [AW-1:0] mem_rd,
  output logic          mem_wr,
  output logic          mem_acc,
  output logic          wb_valid,
  output logic [AW-1:0] wb_rd,
  output logic          wb_wr
);
  logic ex_mem;

  // execute stage copy
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_rs1   <= '0;
      ex_rs2   <= '0;
      ex_rd    <= '0;
      ex_wr    <= 1'b0;
      ex_load  <= 1'b0;
      ex_mem   <= 1'b0;
    end else if (idex_bubble || !id_valid) begin
      ex_valid <= 1'b0;
      ex_wr    <= 1'b0;
      ex_load  <= 1'b0;
      ex_mem   <= 1'b0;
    end else begin
      ex_valid <= 1'b1;
      ex_rs1   <= id_rs1;
      ex_rs2   <= id_rs2;
      ex_rd    <= id_rd;
      ex_wr    <= id_wr;
      ex_load  <= id_load;
      ex_mem   <= id_mem;
    end
  end

  // memory and write-back stage copies
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_rd    <= '0;
      mem_wr    <= 1'b0;
      mem_acc   <= 1'b0;
      wb_valid  <= 1'b0;
      wb_rd     <= '0;
      wb_wr     <= 1'b0;
    end else begin
      mem_valid <= ex_valid;
      mem_rd    <= ex_rd;
      mem_wr    <= ex_wr;
      mem_acc   <= ex_mem;
      wb_valid  <= mem_valid;
      wb_rd     <= mem_rd;
      wb_wr     <= mem_wr;
    end
  end
endmodule

// File: rtl/hz_fwd.sv
module hz_fwd #(
  parameter int AW = 5
) (
  input  logic          ex_valid,
  input  logic [AW-1:0] src,
  input  logic          mem_valid,
  input  logic          mem_wr,
  input  logic [AW-1:0] mem_rd,
  input  logic          wb_valid,
  input  logic          wb_wr,
  input  logic [AW-1:0] wb_rd,
  output logic [1:0]    sel
);
  import hz_pkg::*;
  logic need, hit_mem, hit_wb;

  assign need    = ex_valid && (src != '0);
  assign hit_mem = need && mem_valid && mem_wr && (mem_rd == src);
  assign hit_wb  = need && wb_valid && wb_wr && (wb_rd == src);

  always_comb begin
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hz_stall.sv
module hz_stall #(
  parameter int AW          = 5,
  parameter bit UNIFIED_MEM = 1'b0
) (
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_ctrl,
  input  logic          ex_valid,
  input  logic          ex_load,
  input  logic          ex_wr,
  input  logic [AW-1:0] ex_rd,
  input  logic          mem_valid,
  input  logic          mem_acc,
  output logic          mem_busy,
  output logic          ld_use,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_flush,
  output logic          idex_bubble,
  output logic          redirect
);
  logic ld_dst;

  generate
    if (UNIFIED_MEM) begin : g_shared
      assign mem_busy = mem_valid && mem_acc;
    end else begin : g_split
      assign mem_busy = 1'b0;
    end
  endgenerate

  assign ld_dst = ex_valid && ex_load && ex_wr && (ex_rd != '0);
  assign ld_use = ld_dst && id_valid && ((ex_rd == id_rs1) || (ex_rd == id_rs2));

  // structural stall first, then load-use, then control transfer
  always_comb begin
    pc_hold     = 1'b0;
    ifid_hold   = 1'b0;
    ifid_flush  = 1'b0;
    idex_bubble = 1'b0;
    redirect    = 1'b0;
    if (mem_busy || ld_use) begin
      pc_hold     = 1'b1;
      ifid_hold   = 1'b1;
      idex_bubble = 1'b1;
    end else if (id_valid && id_ctrl) begin
      redirect   = 1'b1;
      ifid_flush = 1'b1;
    end
  end
endmodule

// File: rtl/hz_ctrl_unit.sv
module hz_ctrl_unit #(
  parameter int AW          = 5,
  parameter bit UNIFIED_MEM = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] id_rd,
  input  logic          id_wr,
  input  logic          id_load,
  input  logic          id_mem,
  input  logic          id_ctrl,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_flush,
  output logic          idex_bubble,
  output logic          redirect,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b
);
  localparam int NSRC = 2;

  logic          ex_valid, ex_wr, ex_load;
  logic [AW-1:0] ex_rs1, ex_rs2, ex_rd;
  logic          mem_valid, mem_wr, mem_acc;
  logic [AW-1:0] mem_rd;
  logic          wb_valid, wb_wr;
  logic [AW-1:0] wb_rd;
  logic          mem_busy, ld_use;
  logic [AW-1:0] ex_src [NSRC];
  logic [1:0]    sel    [NSRC];

  hz_track #(.AW(AW)) u_track (
    .clk(clk), .rst(rst), .idex_bubble(idex_bubble),
    .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
    .id_wr(id_wr), .id_load(id_load), .id_mem(id_mem),
    .ex_valid(ex_valid), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
    .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_acc(mem_acc),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_wr(wb_wr)
  );

  hz_stall #(.AW(AW), .UNIFIED_MEM(UNIFIED_MEM)) u_stall (
    .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_ctrl(id_ctrl),
    .ex_valid(ex_valid), .ex_load(ex_load), .ex_wr(ex_wr), .ex_rd(ex_rd),
    .mem_valid(mem_valid), .mem_acc(mem_acc),
    .mem_busy(mem_busy), .ld_use(ld_use),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ifid_flush(ifid_flush),
    .idex_bubble(idex_bubble), .redirect(redirect)
  );

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_fwd
      hz_fwd #(.AW(AW)) u_fwd (
        .ex_valid(ex_valid), .src(ex_src[g]),
        .mem_valid(mem_valid), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .wb_valid(wb_valid), .wb_wr(wb_wr), .wb_rd(wb_rd),
        .sel(sel[g])
      );
    end
  endgenerate

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];
endmodule

// File: rtl/hz_ctrl_unit_chk.sv
module hz_ctrl_unit_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          ifid_flush,
  input logic          idex_bubble,
  input logic          redirect,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          ld_use,
  input logic          mem_busy,
  input logic [AW-1:0] ex_rs1
);
  // R3: redirect always discards the fetched slot and lets fetch proceed
  a_r3_redirect_flushes: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (ifid_flush && !pc_hold));

  // R4: while the front end is frozen no redirect or flush is issued
  a_r4_freeze_wins: assert property (@(posedge clk) disable iff (rst)
    pc_hold |-> (!redirect && !ifid_flush && ifid_hold));

  // R5: a load-use stall lasts one cycle
  a_r5_one_cycle_stall: assert property (@(posedge clk) disable iff (rst)
    ld_use |=> !ld_use);

  // R10: a hold only ever comes from a structural or load-use cause
  a_r10_hold_has_cause: assert property (@(posedge clk) disable iff (rst)
    (pc_hold || idex_bubble) |-> (mem_busy || ld_use));

  // R6: only the three defined select codes appear
  a_r6_sel_legal: assert property (@(posedge clk) disable iff (rst)
    (fwd_a != 2'd3) && (fwd_b != 2'd3));

  // R9: register 0 never forwards
  a_r9_zero_no_fwd: assert property (@(posedge clk) disable iff (rst)
    (fwd_a != 2'd0) |-> (ex_rs1 != '0));

  // R1: first cycle out of reset carries no forward
  a_r1_clean_start: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (fwd_a == 2'd0 && fwd_b == 2'd0));
endmodule

bind hz_ctrl_unit hz_ctrl_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
  .ifid_flush(ifid_flush), .idex_bubble(idex_bubble), .redirect(redirect),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .ld_use(ld_use), .mem_busy(mem_busy),
  .ex_rs1(ex_rs1)
);

// File: tb/sim_hz_ctrl_unit.sv
`timescale 1ns/1ps
module sim_hz_ctrl_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v, wr, ld, mm, ct;
  logic [AW-1:0] s1, s2, d;
  logic ph0, ih0, fl0, bb0, rd0;
  logic ph1, ih1, fl1, bb1, rd1;
  logic [1:0] fa0, fb0, fa1, fb1;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hz_ctrl_unit #(.AW(AW), .UNIFIED_MEM(1'b0)) u0 (
    .clk(clk), .rst(rst), .id_valid(v), .id_rs1(s1), .id_rs2(s2), .id_rd(d),
    .id_wr(wr), .id_load(ld), .id_mem(mm), .id_ctrl(ct),
    .pc_hold(ph0), .ifid_hold(ih0), .ifid_flush(fl0), .idex_bubble(bb0),
    .redirect(rd0), .fwd_a(fa0), .fwd_b(fb0));

  hz_ctrl_unit #(.AW(AW), .UNIFIED_MEM(1'b1)) u1 (
    .clk(clk), .rst(rst), .id_valid(v), .id_rs1(s1), .id_rs2(s2), .id_rd(d),
    .id_wr(wr), .id_load(ld), .id_mem(mm), .id_ctrl(ct),
    .pc_hold(ph1), .ifid_hold(ih1), .ifid_flush(fl1), .idex_bubble(bb1),
    .redirect(rd1), .fwd_a(fa1), .fwd_b(fb1));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // present one decode instruction for one cycle; outputs settle 2 ns later
  task automatic put(input logic pv, input int r1, input int r2, input int rd,
                     input logic pw, input logic pl, input logic pm, input logic pc);
    @(negedge clk);
    v = pv; s1 = AW'(r1); s2 = AW'(r2); d = AW'(rd);
    wr = pw; ld = pl; mm = pm; ct = pc;
    #2;
  endtask

  task automatic nop();
    put(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    v = 0; s1 = 0; s2 = 0; d = 0; wr = 0; ld = 0; mm = 0; ct = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    nop();
    chk("R1 pc_hold", ph1, 0);
    chk("R1 bubble", bb1, 0);
    chk("R1 redirect", rd0, 0);
    chk("R1 fwd_a", fa0, 0);
    // fill pipe with writers, then reset mid-flight
    put(1'b1, 0, 0, 7, 1'b1, 1'b0, 1'b0, 1'b0);
    put(1'b1, 0, 0, 8, 1'b1, 1'b1, 1'b1, 1'b0);
    do_reset();
    put(1'b1, 8, 7, 9, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 no stall after reset", ph0, 0);
    nop();
    chk("R1 fwd_a cleared", fa0, 0);
    chk("R1 fwd_b cleared", fb0, 0);
  endtask

  task automatic t_struct();
    do_reset();
    put(1'b1, 1, 2, 0, 1'b0, 1'b0, 1'b1, 1'b0);  // store
    nop();
    nop();                                        // store now in memory stage
    chk("R2 unified pc_hold", ph1, 1);
    chk("R2 unified ifid_hold", ih1, 1);
    chk("R2 unified bubble", bb1, 1);
    chk("R2 split pc_hold", ph0, 0);
    chk("R2 split bubble", bb0, 0);
  endtask

  task automatic t_ctrl();
    do_reset();
    put(1'b1, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 redirect", rd0, 1);
    chk("R3 ifid_flush", fl0, 1);
    chk("R3 pc_hold", ph0, 0);
    nop();
    chk("R3 redirect one cycle", rd0, 0);
  endtask

  task automatic t_struct_ctrl();
    do_reset();
    put(1'b1, 1, 2, 0, 1'b0, 1'b0, 1'b1, 1'b0);  // store
    nop();
    put(1'b1, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1);  // transfer meets access
    chk("R4 no redirect while frozen", rd1, 0);
    chk("R4 no flush while frozen", fl1, 0);
    chk("R4 decode held", ih1, 1);
    chk("R2 split redirects", rd0, 1);
    put(1'b1, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1);  // held transfer again
    chk("R4 redirect after resume", rd1, 1);
    chk("R4 fetch free after resume", ph1, 0);
  endtask

  task automatic t_load_use();
    do_reset();
    put(1'b1, 1, 2, 5, 1'b1, 1'b1, 1'b1, 1'b0);  // load r5
    put(1'b1, 6, 5, 7, 1'b1, 1'b0, 1'b0, 1'b0);  // reads r5
    chk("R5 stall pc", ph0, 1);
    chk("R5 bubble", bb0, 1);
    put(1'b1, 6, 5, 7, 1'b1, 1'b0, 1'b0, 1'b0);  // same instruction held
    chk("R5 stall one cycle", ph0, 0);
    nop();
    chk("R5 fwd_b from write-back", fb0, 1);
    chk("R5 fwd_a register file", fa0, 0);
  endtask

  task automatic t_fwd();
    do_reset();
    put(1'b1, 0, 0, 3, 1'b1, 1'b0, 1'b0, 1'b0);
    put(1'b1, 0, 0, 4, 1'b1, 1'b0, 1'b0, 1'b0);
    put(1'b1, 3, 4, 9, 1'b1, 1'b0, 1'b0, 1'b0);
    nop();
    chk("R7 fwd_a write-back", fa0, 1);
    chk("R6 fwd_b memory", fb0, 2);
    do_reset();
    put(1'b1, 0, 0, 3, 1'b1, 1'b0, 1'b0, 1'b0);
    put(1'b1, 0, 0, 3, 1'b1, 1'b0, 1'b0, 1'b0);
    put(1'b1, 3, 3, 9, 1'b1, 1'b0, 1'b0, 1'b0);
    nop();
    chk("R8 newer wins a", fa0, 2);
    chk("R8 newer wins b", fb0, 2);
  endtask

  task automatic t_zero_nowr();
    do_reset();
    put(1'b1, 0, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);  // writes r0
    put(1'b1, 0, 0, 6, 1'b0, 1'b0, 1'b0, 1'b0);  // rd=6 but no write
    put(1'b1, 0, 6, 2, 1'b1, 1'b0, 1'b0, 1'b0);
    nop();
    chk("R9 r0 no forward", fa0, 0);
    chk("R11 non-writer no forward", fb0, 0);
    do_reset();
    put(1'b1, 1, 1, 0, 1'b1, 1'b1, 1'b1, 1'b0);  // load to r0
    put(1'b1, 0, 0, 4, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 r0 no load-use stall", ph0, 0);
  endtask

  task automatic t_war_waw();
    do_reset();
    put(1'b1, 6, 0, 2, 1'b1, 1'b0, 1'b0, 1'b0);  // reads r6, writes r2
    put(1'b1, 1, 1, 6, 1'b1, 1'b0, 1'b0, 1'b0);  // WAR on r6
    chk("R10 WAR no hold", ph0, 0);
    put(1'b1, 1, 1, 2, 1'b1, 1'b0, 1'b0, 1'b0);  // WAW on r2
    chk("R10 WAW no hold", ph0, 0);
    chk("R10 WAW no bubble", bb0, 0);
    do_reset();
    put(1'b1, 4, 4, 5, 1'b1, 1'b1, 1'b1, 1'b0);  // load reads r4
    put(1'b1, 1, 2, 4, 1'b1, 1'b0, 1'b0, 1'b0);  // writes r4
    chk("R10 WAR behind load no hold", ph0, 0);
  endtask

  initial begin
    v = 0; s1 = 0; s2 = 0; d = 0; wr = 0; ld = 0; mm = 0; ct = 0;
    t_reset();
    t_struct();
    t_ctrl();
    t_struct_ctrl();
    t_load_use();
    t_fwd();
    t_zero_nowr();
    t_war_waw();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule